// File: doc/BRIEF.md
# Partitioned Physical Register Allocator

This block hands out physical register tags to the rename stage of an out-of-order core and takes them back from commit. The 64-entry physical register file is cut into a parameter-chosen number of equal partitions (2, 4 or 8). New tags are drawn from a single default partition for as long as it has a free entry. When that partition is exhausted, further partitions are switched on one at a time in a configurable activation order. Whenever several switched-on partitions have free entries, the one switched on earliest is always drawn from first. The aim is to keep register file activity packed into as few regions as possible, so that the rest can be power gated and allowed to cool.

A free-running timer moves the default role to the next partition in round-robin order once per rotation period. At that moment every partition in use stops supplying tags. A partition that supplies no tags is gated as soon as it holds no live register. A region that is handed a new register while gated has its gate released at that allocation and reports itself powered two cycles later, before the back end reads it.

Each cycle the block can grant one tag and accept one release. A tag is granted in the same cycle that `alloc_req` is high and `alloc_ready` is high, and the allocator state moves at that clock edge.

Top module: `pra_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, all 64 registers are free, `dflt_part` is 0, `active_mask` holds only bit 0, `pgate_en` is set for every partition except 0, `region_up` holds only bit 0, and `alloc_ready` is 1.
- R2: A tag is `{partition, slot}`, the partition index in the upper log2(NUM_PARTS) bits and the slot in the remaining low bits. While the default partition has a free slot, every grant comes from it, lowest free slot first.
- R3: When every partition in use is full, the grant comes from the next partition in activation order, and that partition joins `active_mask` after the granting edge. Rank k of the order is the partition `(dflt_part + ACT_ORDER[4k+3:4k]) mod NUM_PARTS`, and nibble 0 of `ACT_ORDER` must be 0.
- R4: When more than one partition in use has a free slot, the grant comes from the one with the lowest rank (the one switched on earliest).
- R5: Every `ROT_PERIOD` cycles `dflt_part` advances by one modulo NUM_PARTS, and `active_mask` then holds only the new default.
- R6: After a rotation, grants come from the new default even when partitions that were in use before still have free slots.
- R7: `pgate_en[p]` rises one cycle after partition p is out of `active_mask` with zero live registers. It stays low while the partition holds any live register, and it never rises on a partition in use.
- R8: A grant from a gated partition clears its `pgate_en` at the granting edge. Its `region_up` stays low for the two cycles after that edge and is high in the third cycle.
- R9: `alloc_ready` is low exactly when all 64 registers are live. A request made while it is low changes nothing. A release raises it again in the next cycle.
- R10: An allocation and a release in the same cycle both take effect. The grant of that cycle never returns the tag being released in that cycle.
- R11: A released register goes back to its partition's free pool and is again a candidate for the lowest-free-slot choice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Rename asks for one register this cycle |
| alloc_ready | output | 1 | A free register can be granted this cycle |
| alloc_tag | output | 6 | Tag granted when `alloc_req` and `alloc_ready` are both high |
| rel_valid | input | 1 | Commit returns one register this cycle |
| rel_tag | input | 6 | Tag being returned |
| pgate_en | output | NUM_PARTS | Power-gate enable per register file region (1 = gated) |
| region_up | output | NUM_PARTS | Region powered and past its wakeup time |
| active_mask | output | NUM_PARTS | Partitions currently allowed to supply tags |
| dflt_part | output | log2(NUM_PARTS) | Current default partition |

## Verification
The allocation path and the release path can act on the same partition in the same clock cycle, and both change that partition's free bitmap and live count. The stimulus table contains a vector that requests a tag while it releases a register from the default partition. The vector is judged right when the grant of that cycle is the next untouched slot and not the released tag, and when the following grant then returns the released tag. Rotation can also land on a cycle with a grant. The checker covers that case by requiring, after every rotation, a single partition in use that is the new default.

// File: rtl/pra_pkg.sv
package pra_pkg;

    // Size of the physical register file served by the allocator.
    localparam int unsigned PREG_COUNT = 64;
    localparam int unsigned TAG_W      = $clog2(PREG_COUNT);

    typedef logic [TAG_W-1:0] preg_tag_t;

    // A release request arriving from commit.
    typedef struct packed {
        logic      valid;
        preg_tag_t tag;
    } preg_ret_t;

    // Offset of activation rank k inside the packed order table (4 bits per rank).
    function automatic logic [3:0] order_offset(input logic [31:0] table_code, input int unsigned k);
        return table_code[4*k +: 4];
    endfunction

endpackage

// File: rtl/pra_rot_timer.sv
module pra_rot_timer #(
    parameter int unsigned PERIOD = 10000
) (
    input  logic clk,
    input  logic rst,
    output logic rotate
);
    localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt_q;

    assign rotate = (cnt_q == CW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (rotate) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/pra_pick.sv
module pra_pick #(
    parameter int unsigned NUM_PARTS = 4,
    parameter logic [31:0] ACT_ORDER = 32'h7654_3210
) (
    input  logic [$clog2(NUM_PARTS)-1:0] dflt,
    input  logic [$clog2(NUM_PARTS):0]   act_cnt,
    input  logic [NUM_PARTS-1:0]         has_free,
    output logic                         found,
    output logic [$clog2(NUM_PARTS)-1:0] sel_part,
    output logic [$clog2(NUM_PARTS)-1:0] sel_rank,
    output logic [NUM_PARTS-1:0]         act_mask
);
    import pra_pkg::*;

    localparam int unsigned PW = $clog2(NUM_PARTS);

    // Partition that holds each activation rank under the current default.
    logic [PW-1:0] rank_part [NUM_PARTS];

    for (genvar k = 0; k < NUM_PARTS; k++) begin : g_rank
        assign rank_part[k] = dflt + PW'(order_offset(ACT_ORDER, k));
    end

    // Lowest rank with a free slot wins: scan downwards, last hit stays.
    always_comb begin
        found    = 1'b0;
        sel_part = '0;
        sel_rank = '0;
        for (int k = NUM_PARTS - 1; k >= 0; k--) begin
            if (has_free[rank_part[k]]) begin
                found    = 1'b1;
                sel_part = rank_part[k];
                sel_rank = PW'(k);
            end
        end
    end

    // Ranks below the activation count are the partitions in use.
    always_comb begin
        act_mask = '0;
        for (int k = 0; k < NUM_PARTS; k++) begin
            if (k < int'(act_cnt)) begin
                act_mask[rank_part[k]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pra_slice.sv
module pra_slice #(
    parameter int unsigned SLOTS       = 16,
    parameter int unsigned WAKE_CYCLES = 2,
    parameter logic        RESET_GATED = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     alloc_hit,
    input  logic                     rel_hit,
    input  logic [$clog2(SLOTS)-1:0] rel_slot,
    input  logic                     idle,
    output logic                     has_free,
    output logic [$clog2(SLOTS)-1:0] free_slot,
    output logic                     pgate,
    output logic                     powered
);
    localparam int unsigned SW = $clog2(SLOTS);
    localparam int unsigned CW = $clog2(SLOTS + 1);
    localparam int unsigned WW = $clog2(WAKE_CYCLES + 1);

    logic [SLOTS-1:0] free_q, free_d;
    logic [CW-1:0]    live_q, live_d;
    logic             gate_q;
    logic [WW-1:0]    wcnt_q, wcnt_dec;

    assign has_free = |free_q;

    // Lowest free slot.
    always_comb begin
        free_slot = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (free_q[s]) begin
                free_slot = SW'(s);
            end
        end
    end

    always_comb begin
        free_d = free_q;
        if (alloc_hit) begin
            free_d[free_slot] = 1'b0;
        end
        if (rel_hit) begin
            free_d[rel_slot] = 1'b1;
        end
    end

    assign live_d   = live_q + CW'(alloc_hit) - CW'(rel_hit);
    assign wcnt_dec = (wcnt_q != '0) ? (wcnt_q - WW'(1)) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= '1;
            live_q <= '0;
            gate_q <= RESET_GATED;
            wcnt_q <= '0;
        end else begin
            free_q <= free_d;
            live_q <= live_d;
            if (alloc_hit) begin
                gate_q <= 1'b0;
                wcnt_q <= gate_q ? WW'(WAKE_CYCLES) : wcnt_dec;
            end else if (idle && (live_q == '0)) begin
                gate_q <= 1'b1;
                wcnt_q <= '0;
            end else begin
                wcnt_q <= wcnt_dec;
            end
        end
    end

    assign pgate   = gate_q;
    assign powered = !gate_q && (wcnt_q == '0);
endmodule

// File: rtl/pra_top.sv
module pra_top
    import pra_pkg::*;
#(
    parameter int unsigned NUM_PARTS   = 4,
    parameter int unsigned ROT_PERIOD  = 10000,
    parameter int unsigned WAKE_CYCLES = 2,
    parameter logic [31:0] ACT_ORDER   = 32'h7654_3210
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         alloc_req,
    output logic                         alloc_ready,
    output logic [TAG_W-1:0]             alloc_tag,
    input  logic                         rel_valid,
    input  logic [TAG_W-1:0]             rel_tag,
    output logic [NUM_PARTS-1:0]         pgate_en,
    output logic [NUM_PARTS-1:0]         region_up,
    output logic [NUM_PARTS-1:0]         active_mask,
    output logic [$clog2(NUM_PARTS)-1:0] dflt_part
);
    localparam int unsigned PW    = $clog2(NUM_PARTS);
    localparam int unsigned AW    = PW + 1;
    localparam int unsigned SLOTS = PREG_COUNT / NUM_PARTS;
    localparam int unsigned SW    = $clog2(SLOTS);

    logic [PW-1:0]        dflt_q;
    logic [AW-1:0]        act_cnt_q;
    logic                 rotate;
    logic                 found;
    logic                 grant;
    logic [PW-1:0]        sel_part;
    logic [PW-1:0]        sel_rank;
    logic [NUM_PARTS-1:0] has_free;
    logic [SW-1:0]        slot_free [NUM_PARTS];
    preg_ret_t            ret;
    logic [PW-1:0]        rel_part;
    logic [SW-1:0]        rel_slot;

    assign ret.valid = rel_valid;
    assign ret.tag   = rel_tag;
    assign rel_part  = ret.tag[TAG_W-1 -: PW];
    assign rel_slot  = ret.tag[SW-1:0];

    pra_rot_timer #(
        .PERIOD (ROT_PERIOD)
    ) i_timer (
        .clk    (clk),
        .rst    (rst),
        .rotate (rotate)
    );

    pra_pick #(
        .NUM_PARTS (NUM_PARTS),
        .ACT_ORDER (ACT_ORDER)
    ) i_pick (
        .dflt     (dflt_q),
        .act_cnt  (act_cnt_q),
        .has_free (has_free),
        .found    (found),
        .sel_part (sel_part),
        .sel_rank (sel_rank),
        .act_mask (active_mask)
    );

    for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
        pra_slice #(
            .SLOTS       (SLOTS),
            .WAKE_CYCLES (WAKE_CYCLES),
            .RESET_GATED (p != 0)
        ) i_slice (
            .clk       (clk),
            .rst       (rst),
            .alloc_hit (grant && (sel_part == PW'(p))),
            .rel_hit   (ret.valid && (rel_part == PW'(p))),
            .rel_slot  (rel_slot),
            .idle      (!active_mask[p]),
            .has_free  (has_free[p]),
            .free_slot (slot_free[p]),
            .pgate     (pgate_en[p]),
            .powered   (region_up[p])
        );
    end

    assign alloc_ready = found;
    assign grant       = alloc_req && found;
    assign alloc_tag   = {sel_part, slot_free[sel_part]};
    assign dflt_part   = dflt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dflt_q    <= '0;
            act_cnt_q <= AW'(1);
        end else if (rotate) begin
            dflt_q    <= dflt_q + PW'(1);
            act_cnt_q <= AW'(1);
        end else if (grant && ({1'b0, sel_rank} >= act_cnt_q)) begin
            act_cnt_q <= {1'b0, sel_rank} + AW'(1);
        end
    end
endmodule

// File: rtl/pra_chk.sv
module pra_chk
    import pra_pkg::*;
#(
    parameter int unsigned NUM_PARTS = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         alloc_req,
    input logic                         alloc_ready,
    input logic [$clog2(NUM_PARTS)-1:0] grant_part,
    input logic                         rel_valid,
    input logic [NUM_PARTS-1:0]         pgate_en,
    input logic [NUM_PARTS-1:0]         region_up,
    input logic [NUM_PARTS-1:0]         active_mask,
    input logic [$clog2(NUM_PARTS)-1:0] dflt_part
);
    localparam int unsigned PW = $clog2(NUM_PARTS);
    localparam int unsigned OW = $clog2(PREG_COUNT + 1);

    logic [OW-1:0] occ_q;
    logic          gnt_q;
    logic [PW-1:0] gpart_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q   <= '0;
            gnt_q   <= 1'b0;
            gpart_q <= '0;
        end else begin
            occ_q   <= occ_q + OW'(alloc_req && alloc_ready) - OW'(rel_valid);
            gnt_q   <= alloc_req && alloc_ready;
            gpart_q <= grant_part;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (active_mask == NUM_PARTS'(1)) && (dflt_part == '0)
                       && (pgate_en == ~NUM_PARTS'(1)) && alloc_ready);

    p_default_in_use_r2: assert property (@(posedge clk) disable iff (rst)
        active_mask[dflt_part]);

    p_grant_in_use_r3: assert property (@(posedge clk) disable iff (rst)
        gnt_q && $stable(dflt_part) |-> active_mask[gpart_q]);

    p_rotate_step_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(dflt_part) |-> (dflt_part == PW'($past(dflt_part) + PW'(1)))
                                && ($countones(active_mask) == 1) && active_mask[dflt_part]);

    p_ready_occupancy_r9: assert property (@(posedge clk) disable iff (rst)
        alloc_ready == (occ_q != OW'(PREG_COUNT)));

    for (genvar p = 0; p < NUM_PARTS; p++) begin : g_region
        p_gate_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
            $rose(pgate_en[p]) |-> $past(!active_mask[p]));

        p_up_means_ungated_r8: assert property (@(posedge clk) disable iff (rst)
            region_up[p] |-> !pgate_en[p]);

        p_wake_not_instant_r8: assert property (@(posedge clk) disable iff (rst)
            $fell(pgate_en[p]) |-> !region_up[p]);
    end
endmodule

bind pra_top pra_chk #(
    .NUM_PARTS (NUM_PARTS)
) i_pra_chk (
    .clk         (clk),
    .rst         (rst),
    .alloc_req   (alloc_req),
    .alloc_ready (alloc_ready),
    .grant_part  (alloc_tag[pra_pkg::TAG_W-1 -: PW]),
    .rel_valid   (rel_valid),
    .pgate_en    (pgate_en),
    .region_up   (region_up),
    .active_mask (active_mask),
    .dflt_part   (dflt_part)
);

// File: tb/test_pra_top.sv
`timescale 1ns/1ps
module test_pra_top;
    localparam int NP     = 4;
    localparam int PERIOD = 400;
    localparam int WD_NS  = 200000 * 20;

    typedef struct packed {
        logic       do_alloc;
        logic       do_rel;
        logic [5:0] rtag;
        logic [5:0] exp_tag;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 6'd0, 6'd0},
        '{1'b1, 1'b0, 6'd0, 6'd1},
        '{1'b0, 1'b1, 6'd0, 6'd0},
        '{1'b1, 1'b0, 6'd0, 6'd0},
        '{1'b1, 1'b1, 6'd1, 6'd2},
        '{1'b1, 1'b0, 6'd0, 6'd1},
        '{1'b1, 1'b0, 6'd0, 6'd3}
    };
    localparam string LBL [NV] = '{"R2", "R2", "R11", "R11", "R10", "R11", "R2"};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alloc_req = 1'b0;
    logic          alloc_ready;
    logic [5:0]    alloc_tag;
    logic          rel_valid = 1'b0;
    logic [5:0]    rel_tag = '0;
    logic [NP-1:0] pgate_en, region_up, active_mask;
    logic [1:0]    dflt_part;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pra_top #(
        .NUM_PARTS  (NP),
        .ROT_PERIOD (PERIOD),
        .ACT_ORDER  (32'h0000_3120)
    ) i_pra_top (
        .clk         (clk),
        .rst         (rst),
        .alloc_req   (alloc_req),
        .alloc_ready (alloc_ready),
        .alloc_tag   (alloc_tag),
        .rel_valid   (rel_valid),
        .rel_tag     (rel_tag),
        .pgate_en    (pgate_en),
        .region_up   (region_up),
        .active_mask (active_mask),
        .dflt_part   (dflt_part)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the following negedge.
    task automatic op(input logic a, input logic r, input logic [5:0] rt,
                      output logic [5:0] tag, output logic rdy);
        alloc_req = a;
        rel_valid = r;
        rel_tag   = rt;
        #1;
        tag = alloc_tag;
        rdy = alloc_ready;
        @(negedge clk);
        alloc_req = 1'b0;
        rel_valid = 1'b0;
    endtask

    task automatic wait_rotation(output int when);
        logic [1:0] prev;
        prev = dflt_part;
        when = -1;
        for (int i = 0; i < 2 * PERIOD; i++) begin
            @(negedge clk);
            if (dflt_part != prev) begin
                when = cyc;
                break;
            end
        end
    endtask

    initial begin
        #(WD_NS);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [5:0] t;
        logic       rdy;
        int         rot1, rot2, grants;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 ready", int'(alloc_ready), 1);
        chk("R1 active_mask", int'(active_mask), 1);
        chk("R1 dflt_part", int'(dflt_part), 0);
        chk("R1 pgate_en", int'(pgate_en), 4'b1110);
        chk("R1 region_up", int'(region_up), 4'b0001);

        // Table walk: allocations, releases and a same-cycle pair
        for (int v = 0; v < NV; v++) begin
            op(VECS[v].do_alloc, VECS[v].do_rel, VECS[v].rtag, t, rdy);
            if (VECS[v].do_alloc) chk(LBL[v], int'(t), int'(VECS[v].exp_tag));
        end

        // R2: the rest of the default partition, lowest slot first
        for (int s = 4; s < 16; s++) begin
            op(1'b1, 1'b0, 6'd0, t, rdy);
            chk("R2 fill default", int'(t), s);
        end

        // R3: default full -> rank 1 of order 0,2,1,3 is partition 2, slot 0 = tag 32
        op(1'b1, 1'b0, 6'd0, t, rdy);
        chk("R3 next partition tag", int'(t), 32);
        chk("R3 active_mask", int'(active_mask), 4'b0101);
        // R8: gate dropped at the granting edge, powered two cycles later
        chk("R8 gate cleared", int'(pgate_en[2]), 0);
        chk("R8 up low cycle 1", int'(region_up[2]), 0);
        @(negedge clk);
        chk("R8 up low cycle 2", int'(region_up[2]), 0);
        @(negedge clk);
        chk("R8 up high cycle 3", int'(region_up[2]), 1);

        // R4: a slot freed in the earlier partition is preferred
        op(1'b0, 1'b1, 6'd5, t, rdy);
        op(1'b1, 1'b0, 6'd0, t, rdy);
        chk("R4 earliest partition first", int'(t), 5);
        op(1'b1, 1'b0, 6'd0, t, rdy);
        chk("R4 back to partition 2", int'(t), 33);

        // R5: first rotation
        wait_rotation(rot1);
        chk("R5 dflt after rotation", int'(dflt_part), 1);
        chk("R5 single partition in use", int'(active_mask), 4'b0010);
        chk("R7 idle with live stays powered p0", int'(pgate_en[0]), 0);
        chk("R7 idle with live stays powered p2", int'(pgate_en[2]), 0);
        chk("R7 untouched partition stays gated", int'(pgate_en[3]), 1);

        // R6: new default used though partition 2 has free slots
        op(1'b1, 1'b0, 6'd0, t, rdy);
        chk("R6 grant from new default", int'(t), 16);
        chk("R8 new default ungated", int'(pgate_en[1]), 0);

        // R7: empty the idle partition 2
        op(1'b0, 1'b1, 6'd32, t, rdy);
        op(1'b0, 1'b1, 6'd33, t, rdy);
        chk("R7 gate not yet", int'(pgate_en[2]), 0);
        @(negedge clk);
        chk("R7 gate one cycle later", int'(pgate_en[2]), 1);

        // R5: period between rotations
        wait_rotation(rot2);
        chk("R5 rotation period", rot2 - rot1, PERIOD);
        chk("R5 dflt second rotation", int'(dflt_part), 2);
        chk("R5 mask second rotation", int'(active_mask), 4'b0100);

        // R9: fill everything; order from default 2 is 2,0,3,1
        grants = 0;
        for (int i = 0; i < 60; i++) begin
            if (!alloc_ready) break;
            op(1'b1, 1'b0, 6'd0, t, rdy);
            if (grants == 0) chk("R6 first grant after rotation", int'(t), 32);
            grants++;
        end
        chk("R9 grants until full", grants, 47);
        chk("R9 ready low when full", int'(alloc_ready), 0);
        chk("R3 all partitions in use", int'(active_mask), 4'b1111);

        op(1'b1, 1'b0, 6'd0, t, rdy);
        chk("R9 request while full not granted", int'(rdy), 0);
        chk("R9 still full after ignored request", int'(alloc_ready), 0);
        op(1'b0, 1'b1, 6'd40, t, rdy);
        chk("R9 ready after release", int'(alloc_ready), 1);
        op(1'b1, 1'b0, 6'd0, t, rdy);
        chk("R11 released tag regranted", int'(t), 40);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule